// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns an addressing-mode code and an instruction operand into the 24-bit data address that an 8/16-bit processor core drives for a memory access. It combines the operand with the X or Y index, the direct-page base, the stack pointer and the data bank, according to the selected mode. A compatibility-mode flag switches on the page-locked wrap rules of the older 8-bit processor, and an index-width flag cuts the index registers down to their low byte.

Next to the address, the block predicts the wrong address that the bus touches during a page-crossing dummy read. It also says whether that dummy cycle may be skipped, whether a direct-page penalty cycle is needed, and which mask the sequencer must apply when it steps the address for the second and later bytes of a multi-byte access. Inputs are captured on a one-cycle request strobe, and all results hold until the next strobe.

Top module: `bank_ea_gen`

## Requirements
- R1: In the clock cycle after one with `req_valid_i` high, `res_valid_o` is high and every result output shows the value for the inputs sampled in that cycle. In a cycle with `req_valid_i` low, `res_valid_o` falls and the result outputs keep their previous values, whatever the other inputs do.
- R2: For the absolute indexed modes (code 1 = X write, 2 = X read, 3 = Y write, 4 = Y read), the address is data bank in bits 23:16 and ((operand[15:0] + index) mod 65536) in bits 15:0. Plain absolute (code 0, and also codes 13 to 15) is data bank and operand[15:0].
- R3: For codes 1 to 4, the dummy address is data bank, then operand[15:8], then the low byte of the indexed sum. `skip_dummy_o` is 1 for the read codes 2 and 4 exactly when the dummy address equals the address, and it is always 0 for the write codes 1 and 3. For every other code, the dummy address equals the address and `skip_dummy_o` is 1.
- R4: Direct page (code 7) gives (D + operand[15:0]) mod 65536 in bank 0. `dp_penalty_o` is 1 for codes 7, 8 and 9 exactly when D[7:0] is nonzero, and it is 0 for all other codes.
- R5: Direct indexed (code 8 = X, code 9 = Y) in native mode gives (D + operand + index) mod 65536 in bank 0. In compatibility mode the result is D[15:8] followed by the low byte of that sum, so the address stays within the page.
- R6: Stack relative (code 10) gives (S' + operand) mod 65536 in bank 0. S' is S in native mode and 0x0100 + S[7:0] in compatibility mode.
- R7: When `idx_narrow_i` is 1, the X and Y registers contribute only their low 8 bits to every mode that uses them.
- R8: `wrap_mask_o` is 0x00FFFF for codes 7 to 11, which wrap inside bank 0, and 0xFFFFFF for all other codes.
- R9: Long (code 5) passes the 24-bit operand through unchanged. Long indexed (code 6 = X, code 12 = Y) adds the index to the full 24-bit operand modulo 2^24, so a carry runs into the bank byte.
- R10: Absolute indexed indirect (code 11) gives (operand[15:0] + X) mod 65536 in bank 0.
- R11: While `rst_n` is low at a clock edge, every output is cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Strobe that captures a new computation |
| mode_i | input | 4 | Addressing-mode code (see requirements) |
| operand_i | input | 24 | Instruction operand |
| idx_x_i | input | 16 | X index register |
| idx_y_i | input | 16 | Y index register |
| dpage_i | input | 16 | Direct-page base D |
| stack_i | input | 16 | Stack pointer S |
| dbank_i | input | 8 | Data bank register |
| compat_i | input | 1 | Compatibility (8-bit processor) mode |
| idx_narrow_i | input | 1 | Index registers are 8 bits wide |
| res_valid_o | output | 1 | Result was loaded in the previous cycle |
| ea_o | output | 24 | Effective address |
| dummy_ea_o | output | 24 | Predicted dummy-read address |
| skip_dummy_o | output | 1 | The dummy read may be skipped |
| dp_penalty_o | output | 1 | Add the direct-page penalty cycle |
| wrap_mask_o | output | 24 | Mask for multi-byte address stepping |

## Verification
Absolute indexed accesses are driven with and without a page crossing, and in read and write forms. This separates the dummy-address prediction and the skip rule from the plain sum, and a wrap at 0xFFFF shows that the bank byte is not carried into. Direct indexed and stack relative accesses are repeated with identical inputs in compatibility and native mode, where the page-locked result differs from the full 16-bit sum. The direct-page low byte is set both to zero and to nonzero to drive the penalty flag. A long indexed access is chosen to carry into the bank byte, and an index register with a nonzero high byte is tried under both index widths. Between strobes, the operand and registers are changed to show that the results hold.

// File: rtl/bea_pkg.sv
// Package: shared widths, mode codes and the result record of the
// banked effective address generator.
// Assumes: a 16-bit in-bank offset and an 8-bit bank byte.
package bea_pkg;

    localparam int OFS_W  = 16;
    localparam int BANK_W = 8;
    localparam int ADDR_W = OFS_W + BANK_W;
    localparam int PAGE_W = 8;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_ABS       = 4'd0,
        AM_ABS_X_WR  = 4'd1,
        AM_ABS_X_RD  = 4'd2,
        AM_ABS_Y_WR  = 4'd3,
        AM_ABS_Y_RD  = 4'd4,
        AM_LONG      = 4'd5,
        AM_LONG_X    = 4'd6,
        AM_DIRECT    = 4'd7,
        AM_DIRECT_X  = 4'd8,
        AM_DIRECT_Y  = 4'd9,
        AM_STACK_REL = 4'd10,
        AM_ABS_X_IND = 4'd11,
        AM_LONG_Y    = 4'd12
    } addr_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] dummy;
        logic              skip;
        logic              penalty;
        logic [ADDR_W-1:0] mask;
    } ea_result_t;

endpackage

// File: rtl/bea_index_mux.sv
// Module: bea_index_mux
// Reduces an index register to its effective width.
// Assumes: the 8-bit index form keeps only the low page byte.
module bea_index_mux #(
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic [OFS_W-1:0] raw_i,
    input  logic             narrow_i,
    output logic [OFS_W-1:0] eff_o
);
    localparam int HI_W = OFS_W - PAGE_W;

    // Clear the high byte when the index is 8 bits wide.
    always_comb begin
        eff_o = narrow_i ? {{HI_W{1'b0}}, raw_i[PAGE_W-1:0]} : raw_i;
    end
endmodule

// File: rtl/bea_abs_unit.sv
// Module: bea_abs_unit
// Absolute indexed address, the dummy address a page crossing produces,
// and the dummy-skip decision for read accesses.
// Assumes: the indexed sum wraps inside the data bank.
module bea_abs_unit #(
    parameter int OFS_W  = 16,
    parameter int BANK_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic [OFS_W-1:0]        op_i,
    input  logic [OFS_W-1:0]        idx_i,
    input  logic [BANK_W-1:0]       bank_i,
    input  logic                    is_read_i,
    output logic [OFS_W+BANK_W-1:0] ea_o,
    output logic [OFS_W+BANK_W-1:0] dummy_o,
    output logic                    skip_o
);
    logic [OFS_W-1:0] sum;

    // Add the index to the operand, dropping the carry out of the bank.
    always_comb begin
        sum = op_i + idx_i;
    end

    // Build the real and the predicted dummy address.
    always_comb begin
        ea_o    = {bank_i, sum};
        dummy_o = {bank_i, op_i[OFS_W-1:PAGE_W], sum[PAGE_W-1:0]};
    end

    // A read needs no dummy cycle when no page boundary was crossed.
    always_comb begin
        skip_o = is_read_i && (dummy_o == ea_o);
    end
endmodule

// File: rtl/bea_page_unit.sv
// Module: bea_page_unit
// Base plus operand plus index in bank 0, with an optional page lock
// that keeps the base's high byte and wraps only the low byte.
// Assumes: callers pass zero as the index when none applies.
module bea_page_unit #(
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic [OFS_W-1:0] base_i,
    input  logic [OFS_W-1:0] op_i,
    input  logic [OFS_W-1:0] idx_i,
    input  logic             lock_i,
    output logic [OFS_W-1:0] addr_o
);
    logic [OFS_W-1:0] full_sum;

    // Three-way sum modulo the bank size.
    always_comb begin
        full_sum = base_i + op_i + idx_i;
    end

    // Select the page-locked or the full result.
    always_comb begin
        addr_o = lock_i ? {base_i[OFS_W-1:PAGE_W], full_sum[PAGE_W-1:0]} : full_sum;
    end
endmodule

// File: rtl/bank_ea_gen.sv
// Module: bank_ea_gen (top)
// Captures a mode and register snapshot on a strobe and, one cycle
// later, presents the effective address, dummy address, skip and penalty
// flags and the multi-byte wrap mask. Results hold until the next strobe.
// Assumes: synchronous active-low reset; codes 13 to 15 act as absolute.
module bank_ea_gen
    import bea_pkg::*;
#(
    parameter int OFS_W_P  = OFS_W,
    parameter int BANK_W_P = BANK_W,
    parameter int PAGE_W_P = PAGE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid_i,
    input  logic [MODE_W-1:0]           mode_i,
    input  logic [OFS_W_P+BANK_W_P-1:0] operand_i,
    input  logic [OFS_W_P-1:0]          idx_x_i,
    input  logic [OFS_W_P-1:0]          idx_y_i,
    input  logic [OFS_W_P-1:0]          dpage_i,
    input  logic [OFS_W_P-1:0]          stack_i,
    input  logic [BANK_W_P-1:0]         dbank_i,
    input  logic                        compat_i,
    input  logic                        idx_narrow_i,
    output logic                        res_valid_o,
    output logic [OFS_W_P+BANK_W_P-1:0] ea_o,
    output logic [OFS_W_P+BANK_W_P-1:0] dummy_ea_o,
    output logic                        skip_dummy_o,
    output logic                        dp_penalty_o,
    output logic [OFS_W_P+BANK_W_P-1:0] wrap_mask_o
);
    localparam int AW   = OFS_W_P + BANK_W_P;
    localparam int HI_W = OFS_W_P - PAGE_W_P;
    localparam logic [AW-1:0] MASK_BANK = {{BANK_W_P{1'b0}}, {OFS_W_P{1'b1}}};
    localparam logic [AW-1:0] MASK_FULL = {AW{1'b1}};

    addr_mode_e mode;
    logic [OFS_W_P-1:0] op_lo;
    logic [OFS_W_P-1:0] idx_eff [2];
    logic [OFS_W_P-1:0] abs_idx;
    logic [OFS_W_P-1:0] dp_idx;
    logic [OFS_W_P-1:0] stk_base;
    logic [OFS_W_P-1:0] dp_addr;
    logic [OFS_W_P-1:0] stk_addr;
    logic [AW-1:0]      abs_ea;
    logic [AW-1:0]      abs_dummy;
    logic               abs_skip;
    logic               abs_is_read;
    logic               dp_lock;
    ea_result_t         nxt;

    // Decode the mode code and the in-bank part of the operand.
    always_comb begin
        mode  = addr_mode_e'(mode_i);
        op_lo = operand_i[OFS_W_P-1:0];
    end

    // Effective-width copies of X (slot 0) and Y (slot 1).
    for (genvar g = 0; g < 2; g++) begin : g_idx
        bea_index_mux #(.OFS_W(OFS_W_P), .PAGE_W(PAGE_W_P)) idx_mux_i (
            .raw_i    ((g == 0) ? idx_x_i : idx_y_i),
            .narrow_i (idx_narrow_i),
            .eff_o    (idx_eff[g])
        );
    end

    // Pick the index and the read flag for the absolute indexed unit.
    always_comb begin
        abs_idx     = ((mode == AM_ABS_Y_WR) || (mode == AM_ABS_Y_RD)) ? idx_eff[1] : idx_eff[0];
        abs_is_read = (mode == AM_ABS_X_RD) || (mode == AM_ABS_Y_RD);
    end

    bea_abs_unit #(.OFS_W(OFS_W_P), .BANK_W(BANK_W_P), .PAGE_W(PAGE_W_P)) abs_i (
        .op_i      (op_lo),
        .idx_i     (abs_idx),
        .bank_i    (dbank_i),
        .is_read_i (abs_is_read),
        .ea_o      (abs_ea),
        .dummy_o   (abs_dummy),
        .skip_o    (abs_skip)
    );

    // Index and page lock for the direct-page unit.
    always_comb begin
        unique case (mode)
            AM_DIRECT_X: dp_idx = idx_eff[0];
            AM_DIRECT_Y: dp_idx = idx_eff[1];
            default:     dp_idx = '0;
        endcase
        dp_lock = compat_i && ((mode == AM_DIRECT_X) || (mode == AM_DIRECT_Y));
    end

    bea_page_unit #(.OFS_W(OFS_W_P), .PAGE_W(PAGE_W_P)) dp_i (
        .base_i (dpage_i),
        .op_i   (op_lo),
        .idx_i  (dp_idx),
        .lock_i (dp_lock),
        .addr_o (dp_addr)
    );

    // The compatibility stack lives in page 1 of bank 0.
    always_comb begin
        stk_base = compat_i ? {{(HI_W-1){1'b0}}, 1'b1, stack_i[PAGE_W_P-1:0]} : stack_i;
    end

    bea_page_unit #(.OFS_W(OFS_W_P), .PAGE_W(PAGE_W_P)) stk_i (
        .base_i (stk_base),
        .op_i   (op_lo),
        .idx_i  ('0),
        .lock_i (1'b0),
        .addr_o (stk_addr)
    );

    // Assemble the result record for the selected mode.
    always_comb begin
        nxt.ea      = {dbank_i, op_lo};
        nxt.penalty = 1'b0;
        nxt.mask    = MASK_FULL;
        unique case (mode)
            AM_ABS_X_WR, AM_ABS_X_RD, AM_ABS_Y_WR, AM_ABS_Y_RD:
                nxt.ea = abs_ea;
            AM_LONG:
                nxt.ea = operand_i;
            AM_LONG_X:
                nxt.ea = operand_i + {{BANK_W_P{1'b0}}, idx_eff[0]};
            AM_LONG_Y:
                nxt.ea = operand_i + {{BANK_W_P{1'b0}}, idx_eff[1]};
            AM_DIRECT, AM_DIRECT_X, AM_DIRECT_Y: begin
                nxt.ea      = {{BANK_W_P{1'b0}}, dp_addr};
                nxt.penalty = |dpage_i[PAGE_W_P-1:0];
                nxt.mask    = MASK_BANK;
            end
            AM_STACK_REL: begin
                nxt.ea   = {{BANK_W_P{1'b0}}, stk_addr};
                nxt.mask = MASK_BANK;
            end
            AM_ABS_X_IND: begin
                nxt.ea   = {{BANK_W_P{1'b0}}, op_lo + idx_eff[0]};
                nxt.mask = MASK_BANK;
            end
            default: ;
        endcase
    end

    // Dummy address and skip: only the absolute indexed modes predict a crossing.
    always_comb begin
        if ((mode == AM_ABS_X_WR) || (mode == AM_ABS_X_RD) ||
            (mode == AM_ABS_Y_WR) || (mode == AM_ABS_Y_RD)) begin
            nxt.dummy = abs_dummy;
            nxt.skip  = abs_skip;
        end else begin
            nxt.dummy = nxt.ea;
            nxt.skip  = 1'b1;
        end
    end

    // Result register: loads on a strobe, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o  <= 1'b0;
            ea_o         <= '0;
            dummy_ea_o   <= '0;
            skip_dummy_o <= 1'b0;
            dp_penalty_o <= 1'b0;
            wrap_mask_o  <= '0;
        end else begin
            res_valid_o <= req_valid_i;
            if (req_valid_i) begin
                ea_o         <= nxt.ea;
                dummy_ea_o   <= nxt.dummy;
                skip_dummy_o <= nxt.skip;
                dp_penalty_o <= nxt.penalty;
                wrap_mask_o  <= nxt.mask;
            end
        end
    end
endmodule

// File: rtl/bea_checker.sv
// Module: bea_checker
// Temporal properties of bank_ea_gen, bound to every instance of it.
// Assumes: the port names of the top module.
module bea_checker #(
    parameter int AW     = 24,
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic [OFS_W-1:0]  dpage_i,
    input logic              res_valid_o,
    input logic [AW-1:0]     ea_o,
    input logic [AW-1:0]     dummy_ea_o,
    input logic              skip_dummy_o,
    input logic              dp_penalty_o,
    input logic [AW-1:0]     wrap_mask_o
);
    localparam int BANK_W = AW - OFS_W;

    // R1: a strobe produces a valid result on the next cycle.
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> res_valid_o);

    // R1: without a strobe the results hold.
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> ($stable(ea_o) && $stable(dummy_ea_o) &&
                          $stable(skip_dummy_o) && $stable(wrap_mask_o)));

    // R3: skipping is only allowed when the dummy address is the real one.
    a_r3_skip_only_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (dummy_ea_o != ea_o) |-> !skip_dummy_o);

    // R4: a penalty only arises for direct modes, which live in bank 0.
    a_r4_penalty_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        dp_penalty_o |-> (ea_o[AW-1:OFS_W] == {BANK_W{1'b0}}));

    // R4: an aligned direct page never costs a penalty cycle.
    a_r4_aligned_no_penalty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (dpage_i[PAGE_W-1:0] == '0)) |=> !dp_penalty_o);

    // R8: the wrap mask is one of the two legal masks.
    a_r8_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ((wrap_mask_o == {AW{1'b1}}) ||
                         (wrap_mask_o == {{BANK_W{1'b0}}, {OFS_W{1'b1}}})));
endmodule

bind bank_ea_gen bea_checker #(
    .AW     (OFS_W_P + BANK_W_P),
    .OFS_W  (OFS_W_P),
    .PAGE_W (PAGE_W_P)
) bea_checker_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .dpage_i      (dpage_i),
    .res_valid_o  (res_valid_o),
    .ea_o         (ea_o),
    .dummy_ea_o   (dummy_ea_o),
    .skip_dummy_o (skip_dummy_o),
    .dp_penalty_o (dp_penalty_o),
    .wrap_mask_o  (wrap_mask_o)
);

// File: tb/bank_ea_gen_tb_top.sv
// Bench: a behavioural reference computed with integers, updated on every
// rising edge and compared with the design on every falling edge.
module bank_ea_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [23:0] operand = '0;
    logic [15:0] idx_x = '0, idx_y = '0, dpage = '0, stack = '0;
    logic [7:0]  dbank = '0;
    logic        compat = 1'b0, narrow = 1'b0;

    logic        res_valid;
    logic [23:0] ea, dummy_ea, wrap_mask;
    logic        skip_dummy, dp_penalty;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bank_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .mode_i(mode),
        .operand_i(operand), .idx_x_i(idx_x), .idx_y_i(idx_y), .dpage_i(dpage),
        .stack_i(stack), .dbank_i(dbank), .compat_i(compat), .idx_narrow_i(narrow),
        .res_valid_o(res_valid), .ea_o(ea), .dummy_ea_o(dummy_ea),
        .skip_dummy_o(skip_dummy), .dp_penalty_o(dp_penalty), .wrap_mask_o(wrap_mask)
    );

    // Reference state.
    int    m_valid = 0, m_ea = 0, m_dummy = 0, m_skip = 0, m_pen = 0, m_mask = 0;
    string m_tag = "R11";

    function automatic string tag_of(int md);
        case (md)
            1, 2, 3, 4: return "R2/R3";
            5, 6, 12:   return "R9";
            7:          return "R4";
            8, 9:       return "R5";
            10:         return "R6";
            11:         return "R10";
            default:    return "R2";
        endcase
    endfunction

    // Reference model: compute the expected record from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_ea = 0; m_dummy = 0; m_skip = 0; m_pen = 0; m_mask = 0;
            m_tag = "R11";
        end else begin
            m_valid = req_valid;
            if (req_valid) begin
                int xe, ye, op16, sum, s2, md;
                md   = mode;
                xe   = narrow ? (idx_x % 256) : idx_x;
                ye   = narrow ? (idx_y % 256) : idx_y;
                op16 = operand % 65536;
                m_pen = 0; m_skip = 1; m_mask = 'hFFFFFF;
                m_ea = dbank * 65536 + op16;
                case (md)
                    1, 2, 3, 4: begin
                        sum = (op16 + ((md <= 2) ? xe : ye)) % 65536;
                        m_ea = dbank * 65536 + sum;
                        m_dummy = dbank * 65536 + (op16 / 256) * 256 + sum % 256;
                        m_skip = (md == 2 || md == 4) ? int'(m_dummy == m_ea) : 0;
                    end
                    5:  m_ea = operand;
                    6:  m_ea = (operand + xe) % (1 << 24);
                    12: m_ea = (operand + ye) % (1 << 24);
                    7: begin
                        m_ea = (dpage + op16) % 65536;
                        m_pen = (dpage % 256) != 0; m_mask = 'hFFFF;
                    end
                    8, 9: begin
                        sum = dpage + op16 + ((md == 8) ? xe : ye);
                        m_ea = compat ? ((dpage / 256) * 256 + sum % 256) : sum % 65536;
                        m_pen = (dpage % 256) != 0; m_mask = 'hFFFF;
                    end
                    10: begin
                        s2 = compat ? (256 + stack % 256) : stack;
                        m_ea = (s2 + op16) % 65536; m_mask = 'hFFFF;
                    end
                    11: begin
                        m_ea = (op16 + xe) % 65536; m_mask = 'hFFFF;
                    end
                    default: ;
                endcase
                if (!(md >= 1 && md <= 4)) m_dummy = m_ea;
                m_tag = tag_of(md);
                if (narrow) m_tag = {m_tag, "/R7"};
                m_tag = {m_tag, "/R8"};
            end else begin
                m_tag = "R1";
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (res_valid !== m_valid[0] || ea !== m_ea[23:0] || dummy_ea !== m_dummy[23:0] ||
                skip_dummy !== m_skip[0] || dp_penalty !== m_pen[0] || wrap_mask !== m_mask[23:0]) begin
                n_fail++;
                $display("FAIL %s: got v=%0b ea=%06h dm=%06h sk=%0b pn=%0b mk=%06h exp v=%0b ea=%06h dm=%06h sk=%0b pn=%0b mk=%06h",
                         m_tag, res_valid, ea, dummy_ea, skip_dummy, dp_penalty, wrap_mask,
                         m_valid[0], m_ea[23:0], m_dummy[23:0], m_skip[0], m_pen[0], m_mask[23:0]);
            end
        end
    end

    // One request, then one idle cycle with scrambled inputs to test holding (R1).
    task automatic req(input int md, input int op, input int x, input int y,
                       input int d, input int s, input int b, input bit cm, input bit nw);
        @(posedge clk); #1;
        mode = 4'(md); operand = 24'(op); idx_x = 16'(x); idx_y = 16'(y);
        dpage = 16'(d); stack = 16'(s); dbank = 8'(b); compat = cm; narrow = nw;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        operand = ~operand; idx_x = ~idx_x; dpage = ~dpage; mode = ~mode;
        @(posedge clk); #1;
    endtask

    // Watchdog.
    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state.
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2/R3: absolute X read, no crossing, skip expected.
        req(2, 'h001234, 'h0010, 0, 0, 0, 'h07, 0, 0);
        // R3: crossing on read, no skip.
        req(2, 'h0012F0, 'h0020, 0, 0, 0, 'h07, 0, 0);
        // R3: write variant never skips.
        req(1, 'h001234, 'h0010, 0, 0, 0, 'h07, 0, 0);
        // R2: wrap at bank end does not touch bank.
        req(4, 'h00FFF0, 0, 'h0020, 0, 0, 'h07, 0, 0);
        req(3, 'h001200, 0, 'h0105, 0, 0, 'h3C, 0, 0);
        // R2: plain absolute and an undefined code.
        req(0, 'hAB1234, 0, 0, 0, 0, 'h55, 0, 0);
        req(14, 'hAB4321, 0, 0, 0, 0, 'h55, 0, 0);
        // R7: narrow index with a nonzero high byte, both widths.
        req(2, 'h001200, 'h12FF, 0, 0, 0, 'h01, 0, 1);
        req(2, 'h001200, 'h12FF, 0, 0, 0, 'h01, 0, 0);
        // R9: long, long X with carry into bank, long Y.
        req(5, 'h9A8765, 0, 0, 0, 0, 0, 0, 0);
        req(6, 'h12FFF0, 'h0020, 0, 0, 0, 0, 0, 0);
        req(12, 'hFFFFFF, 0, 'h0002, 0, 0, 0, 0, 0);
        // R4: direct with aligned and unaligned D.
        req(7, 'h000040, 0, 0, 'h2200, 0, 'h33, 0, 0);
        req(7, 'h0000F0, 0, 0, 'hFF21, 0, 'h33, 0, 0);
        // R5: direct indexed, compat versus native.
        req(8, 'h0000F0, 'h0020, 0, 'h0300, 0, 0, 1, 1);
        req(8, 'h0000F0, 'h0020, 0, 'h0300, 0, 0, 0, 1);
        req(9, 'h0000F0, 0, 'h0030, 'h0302, 0, 0, 1, 1);
        req(9, 'h0000F0, 0, 'h1130, 'hFF02, 0, 0, 0, 0);
        // R6: stack relative, compat versus native.
        req(10, 'h000020, 0, 0, 0, 'h12F0, 0, 1, 0);
        req(10, 'h000020, 0, 0, 0, 'h12F0, 0, 0, 0);
        // R10: absolute indexed indirect wraps in bank 0.
        req(11, 'h34FFF0, 'h0020, 0, 0, 0, 'h77, 0, 0);
        // R11: reset mid-run clears outputs.
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule